// File: doc/BRIEF.md
# Multi-Device Serial DAC Command Sender

This block is a host-side master that delivers 16-bit command words to up to four serial DAC slaves. The slaves share one serial clock line and one serial data line. Each slave has its own active-low frame select, driven by a 2-to-4 decoder from a registered device address. A request carries a device address, a control byte, a data byte and a transfer-shape flag. The request is taken through a valid/ready handshake, and only while the sender is idle.

The serial clock idles low and is built from the system clock by a programmable half-period count. Data moves on falling edges, so it is steady when the slave samples it on the rising edge. A word goes out either as one unbroken 16-bit burst or as two byte bursts with a stretched low pause between them. In both shapes the frame select stays low across the whole word.

Select setup before the first rising edge, select hold after the last falling edge, the minimum select-high gap between frames and the byte pause are parameters counted in system clock cycles. The decoder enable is dropped before the address register may change and is raised only after a settle interval. Because of this, a slave that is not addressed never sees a select pulse.

Top module: `dac_cmd_sender`

## Requirements
- R1: While reset is held and immediately after it, every select is high, `sclk` and `sdo` are low, `req_ready` is high and `done` is low.
- R2: Each frame carries exactly 16 rising `sclk` edges. The bits sampled on those edges are `req_ctrl` bits 7 down to 0 followed by `req_data` bits 7 down to 0.
- R3: `sdo` changes only while `sclk` is low. It never changes between two consecutive high samples of `sclk`.
- R4: Every `sclk` high phase lasts exactly DIV_HALF system cycles. Every low phase between two rising edges lasts DIV_HALF cycles, except the one named in R7.
- R5: `sel_n[i]` is the select for device i. Only bit `req_addr` of `sel_n` goes low for a request, and at most one bit is ever low.
- R6: Once a select is low, the `sel_n` pattern does not change until every select is high again. No device other than the addressed one sees a falling select edge.
- R7: With `req_split` = 1, the low phase between the 8th and 9th rising edges lasts DIV_HALF + T_BYTE cycles and the select stays low through it. With `req_split` = 0, that low phase lasts DIV_HALF cycles.
- R8: The select is low for exactly T_SETUP cycles before the first rising `sclk` edge. It stays low for exactly T_HOLD cycles after the last falling edge.
- R9: Between two frames every select stays high for at least T_GAP cycles.
- R10: A request is accepted only when `req_ready` is high. `req_ready` drops in the cycle after acceptance and stays low until the frame ends. A `req_valid` raised while busy starts no frame.
- R11: `done` is a one-cycle pulse. It rises in the cycle after the select has been high for T_GAP cycles, and `req_ready` is high in that cycle.
- R12: `sclk` is low whenever no select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sender idle, request may be taken |
| req_addr | input | AW | Target device index |
| req_ctrl | input | 8 | Control byte, sent first |
| req_data | input | 8 | Data byte, sent second |
| req_split | input | 1 | 1 = two byte bursts, 0 = one 16-bit burst |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data, MSB first |
| sel_n | output | NDEV | Active-low per-device frame selects |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
Words of all zeros, all ones, alternating bits and mixed bytes are sent so that a dropped, duplicated or swapped bit or byte is visible in the captured word. Every device address is used, which separates a correct decoder from one that selects a neighbour or asserts two selects. Each shape of transfer is timed edge by edge, so a missing byte pause or a pause in the wrong place shows up as a wrong low-phase length. A request raised while busy and back-to-back requests show whether the handshake gates acceptance and whether the select-high gap holds.

// File: rtl/dac_cmd_sender.sv
module dac_cmd_sender #(
  parameter int NDEV     = 4,
  parameter int DIV_HALF = 4,
  parameter int T_ADDR   = 1,
  parameter int T_SETUP  = 2,
  parameter int T_HOLD   = 2,
  parameter int T_GAP    = 7,
  parameter int T_BYTE   = 4,
  localparam int AW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic [7:0]      req_ctrl,
  input  logic [7:0]      req_data,
  input  logic            req_split,
  output logic            sclk,
  output logic            sdo,
  output logic [NDEV-1:0] sel_n,
  output logic            done
);
  localparam int LO_MAX = DIV_HALF + T_BYTE;
  localparam int M1 = (LO_MAX > T_GAP) ? LO_MAX : T_GAP;
  localparam int M2 = (T_SETUP > T_HOLD) ? T_SETUP : T_HOLD;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int M4 = (M3 > T_ADDR) ? M3 : T_ADDR;
  localparam int CW = $clog2(M4 + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SETUP, S_HI, S_LO, S_HOLD, S_GAP} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [3:0]    bcnt;
  logic [15:0]   shreg;
  logic [AW-1:0] addr_q;
  logic          dec_en, sclk_q, split_q, done_q;
  logic          last;

  assign last      = (cnt == '0);
  assign req_ready = (state == S_IDLE);
  assign sclk      = sclk_q;
  assign sdo       = shreg[15];
  assign done      = done_q;

  for (genvar i = 0; i < NDEV; i++) begin : g_dec
    assign sel_n[i] = !(dec_en && (addr_q == AW'(i)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bcnt    <= '0;
      shreg   <= '0;
      addr_q  <= '0;
      dec_en  <= 1'b0;
      sclk_q  <= 1'b0;
      split_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          shreg   <= {req_ctrl, req_data};
          split_q <= req_split;
          bcnt    <= '0;
          cnt     <= CW'(T_ADDR - 1);
          state   <= S_ADDR;
        end
        S_ADDR: if (last) begin
          dec_en <= 1'b1;
          cnt    <= CW'(T_SETUP - 1);
          state  <= S_SETUP;
        end else cnt <= cnt - 1'b1;
        S_SETUP: if (last) begin
          sclk_q <= 1'b1;
          cnt    <= CW'(DIV_HALF - 1);
          state  <= S_HI;
        end else cnt <= cnt - 1'b1;
        S_HI: if (last) begin
          sclk_q <= 1'b0;
          shreg  <= {shreg[14:0], 1'b0};
          if (bcnt == 4'd15) begin
            cnt   <= CW'(T_HOLD - 1);
            state <= S_HOLD;
          end else begin
            bcnt  <= bcnt + 1'b1;
            cnt   <= (split_q && bcnt == 4'd7) ? CW'(LO_MAX - 1) : CW'(DIV_HALF - 1);
            state <= S_LO;
          end
        end else cnt <= cnt - 1'b1;
        S_LO: if (last) begin
          sclk_q <= 1'b1;
          cnt    <= CW'(DIV_HALF - 1);
          state  <= S_HI;
        end else cnt <= cnt - 1'b1;
        S_HOLD: if (last) begin
          dec_en <= 1'b0;
          cnt    <= CW'(T_GAP - 1);
          state  <= S_GAP;
        end else cnt <= cnt - 1'b1;
        S_GAP: if (last) begin
          done_q <= 1'b1;
          state  <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_cmd_sender_chk.sv
module dac_cmd_sender_chk #(
  parameter int NDEV  = 4,
  parameter int T_GAP = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            sclk,
  input logic            sdo,
  input logic [NDEV-1:0] sel_n,
  input logic            done
);
  logic [15:0] gap_c;
  logic        seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_c <= '0;
      seen  <= 1'b0;
    end else if (&sel_n) begin
      if (gap_c != 16'hFFFF) gap_c <= gap_c + 1'b1;
    end else begin
      gap_c <= '0;
      seen  <= 1'b1;
    end
  end

  a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sel_n));
  a_r3_sdo_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo));
  a_r12_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (&sel_n) |-> !sclk);
  a_r6_select_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&sel_n) && !(&$past(sel_n))) |-> (sel_n == $past(sel_n)));
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_ready_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  a_r10_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r9_gap_min: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !(&sel_n) && $past(&sel_n)) |-> (gap_c >= 16'(T_GAP)));
endmodule

bind dac_cmd_sender dac_cmd_sender_chk #(.NDEV(NDEV), .T_GAP(T_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .sclk(sclk), .sdo(sdo), .sel_n(sel_n), .done(done)
);

// File: tb/dac_cmd_sender_bench.sv
module dac_cmd_sender_bench;
  localparam int NDEV = 4, DIV_HALF = 4, T_ADDR = 1, T_SETUP = 2, T_HOLD = 2, T_GAP = 7, T_BYTE = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_split = 0;
  logic [1:0] req_addr = 0;
  logic [7:0] req_ctrl = 0, req_data = 0;
  logic req_ready, sclk, sdo, done;
  logic [NDEV-1:0] sel_n;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  dac_cmd_sender #(.NDEV(NDEV), .DIV_HALF(DIV_HALF), .T_ADDR(T_ADDR), .T_SETUP(T_SETUP),
                   .T_HOLD(T_HOLD), .T_GAP(T_GAP), .T_BYTE(T_BYTE)) u_dac_cmd_sender (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_ctrl(req_ctrl), .req_data(req_data), .req_split(req_split),
    .sclk(sclk), .sdo(sdo), .sel_n(sel_n), .done(done));

  // behavioural slave and timing monitor, sampled on the falling system clock edge
  logic [NDEV-1:0] prev_sel = '1;
  logic prev_sclk = 0, prev_sdo = 0;
  int run = 0, gap_run = 0, gap_seen = 0, gap_viol = 0, sdo_viol = 0, idle_viol = 0;
  int bits = 0, cur_dev = -1, setup_len = 0, hold_len = 0, hi_min = 0, hi_max = 0;
  int lo_len [16];
  int falls [NDEV];
  int frame_cnt = 0, last_dev = -1, last_bits = 0;
  logic [15:0] cap = 0, last_word = 0;

  initial for (int i = 0; i < NDEV; i++) falls[i] = 0;

  always @(negedge clk) if (rst_n) begin
    for (int i = 0; i < NDEV; i++) if (prev_sel[i] && !sel_n[i]) falls[i]++;
    if (sclk && prev_sclk && sdo != prev_sdo) sdo_viol++;
    if ((&sel_n) && sclk) idle_viol++;
    if (!(&sel_n) && (&prev_sel)) begin
      if (gap_seen && gap_run < T_GAP) gap_viol++;
      gap_seen = 1; gap_run = 0;
      bits = 0; cap = 0; run = 1; hi_min = 1000; hi_max = 0;
      for (int k = 0; k < 16; k++) lo_len[k] = 0;
      cur_dev = -1;
      for (int i = 0; i < NDEV; i++) if (!sel_n[i]) cur_dev = i;
    end else if ((&sel_n) && !(&prev_sel)) begin
      hold_len = run; last_word = cap; last_bits = bits; last_dev = cur_dev;
      frame_cnt++; gap_run = 1;
    end else if (!(&sel_n)) begin
      if (sclk != prev_sclk) begin
        if (prev_sclk) begin
          if (run < hi_min) hi_min = run;
          if (run > hi_max) hi_max = run;
        end else if (bits == 0) setup_len = run;
        else if (bits < 16) lo_len[bits] = run;
        if (sclk) begin bits++; cap = {cap[14:0], sdo}; end
        run = 1;
      end else run++;
    end else gap_run++;
    prev_sel = sel_n; prev_sclk = sclk; prev_sdo = sdo;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", wd);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R11 done seen", done, 1);
    chk(req_ready == 1'b1, "R11 ready with done", req_ready, 1);
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", done, 0);
  endtask

  task automatic issue(input logic [1:0] a, input logic [7:0] c, input logic [7:0] d, input logic s);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_ctrl = c; req_data = d; req_split = s;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 1'b0, "R10 busy after accept", req_ready, 0);
  endtask

  task automatic verify(input logic [1:0] a, input logic [7:0] c, input logic [7:0] d,
                        input logic s, input int f_before [NDEV]);
    bit lo_ok = 1;
    chk(last_word == {c, d}, "R2 word", last_word, {c, d});
    chk(last_bits == 16, "R2 edge count", last_bits, 16);
    chk(last_dev == int'(a), "R5 device", last_dev, a);
    chk(setup_len == T_SETUP, "R8 setup", setup_len, T_SETUP);
    chk(hold_len == T_HOLD, "R8 hold", hold_len, T_HOLD);
    chk(hi_min == DIV_HALF && hi_max == DIV_HALF, "R4 high phase", hi_max, DIV_HALF);
    for (int k = 1; k < 16; k++) begin
      int e = (s && k == 8) ? DIV_HALF + T_BYTE : DIV_HALF;
      if (lo_len[k] != e) begin
        lo_ok = 0;
        chk(0, (k == 8) ? "R7 byte pause" : "R4 low phase", lo_len[k], e);
      end
    end
    if (lo_ok) chk(1, "R4 R7 low phases", 0, 0);
    for (int i = 0; i < NDEV; i++)
      chk(falls[i] == f_before[i] + ((i == int'(a)) ? 1 : 0), "R6 select edges", falls[i],
          f_before[i] + ((i == int'(a)) ? 1 : 0));
    chk(sdo_viol == 0, "R3 sdo stable high", sdo_viol, 0);
    chk(idle_viol == 0, "R12 sclk idle low", idle_viol, 0);
    chk(gap_viol == 0, "R9 select gap", gap_viol, 0);
  endtask

  task automatic send_and_check(input logic [1:0] a, input logic [7:0] c, input logic [7:0] d, input logic s);
    int fb [NDEV];
    for (int i = 0; i < NDEV; i++) fb[i] = falls[i];
    issue(a, c, d, s);
    wait_done();
    verify(a, c, d, s, fb);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(sel_n == '1, "R1 selects high", sel_n, 4'hF);
    chk(sclk == 0 && sdo == 0, "R1 sclk sdo low", {sclk, sdo}, 0);
    chk(req_ready == 1 && done == 0, "R1 ready done", {req_ready, done}, 2);
  endtask

  task automatic t_continuous();
    send_and_check(2'd0, 8'hA5, 8'h3C, 1'b0);
    send_and_check(2'd1, 8'h00, 8'h00, 1'b0);
    send_and_check(2'd3, 8'hFF, 8'hFF, 1'b0);
  endtask

  task automatic t_split();
    send_and_check(2'd2, 8'hFF, 8'h00, 1'b1);
    send_and_check(2'd0, 8'hAA, 8'h55, 1'b1);
    send_and_check(2'd3, 8'h81, 8'h7E, 1'b1);
  endtask

  task automatic t_busy();
    int fb [NDEV];
    int fc;
    for (int i = 0; i < NDEV; i++) fb[i] = falls[i];
    fc = frame_cnt;
    issue(2'd1, 8'h12, 8'h34, 1'b0);
    req_valid = 1; req_addr = 2'd2; req_ctrl = 8'hEE; req_data = 8'hDD;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R10 ready low while busy", req_ready, 0);
    end
    req_valid = 0;
    wait_done();
    verify(2'd1, 8'h12, 8'h34, 1'b0, fb);
    repeat (40) @(negedge clk);
    chk(frame_cnt == fc + 1, "R10 busy request ignored", frame_cnt, fc + 1);
    chk(falls[2] == fb[2], "R10 no select on ignored device", falls[2], fb[2]);
  endtask

  task automatic t_back_to_back();
    for (int r = 0; r < 4; r++)
      send_and_check(2'(r), 8'(8'h11 * r + 8'h0F), 8'(8'hF0 - 8'h21 * r), 1'(r & 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_continuous();
    t_split();
    t_busy();
    t_back_to_back();
    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule